// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits between the cores and a four-bank DRAM command port. It accepts one memory request per cycle into an eight-slot buffer. Each request names a thread, a bank, a row and a column. Every cycle it offers one pending request downstream. A request that targets the row already open in its bank goes first. Among requests of the same kind, the one that has waited longest goes first. The aim is to get the most out of open rows, because reopening a row costs much more than reading from an open one.

For each bank the block remembers whether a row is open and, if so, which one. When a request is handed off, its bank is marked open on that request's row. Each issued request comes with a two-bit class code, so the DRAM sequencer knows whether it needs a precharge, an activate, or only a column command.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset, `enq_ready` is 1, `iss_valid` is 0, and every bank is treated as having no open row. The first request to any bank is issued with class 0.
- R2: The buffer holds at most 8 requests. With 8 pending, `enq_ready` is 0 and a request offered on `enq_valid` is dropped and never issued.
- R3: A request taken in at a clock edge cannot be offered in the cycle before that edge. `iss_valid` for a request sent to an empty block rises in the cycle that follows its acceptance.
- R4: `iss_class` is 0 when the bank has no open row, 1 when the open row equals the request's row, and 2 when a different row is open.
- R5: A pending request of class 1 is always issued before any pending request of another class, even an older one.
- R6: Among pending requests of the same class, the request accepted earliest is issued first.
- R7: When two requests have the same class and the same 8-bit arrival stamp (stamps taken 256 cycles apart), the request in the lower buffer slot wins. Free slots are filled lowest index first.
- R8: A request leaves only on a cycle with both `iss_valid` and `iss_ready` high. While `iss_ready` is low, `iss_valid` stays high and nothing is lost.
- R9: On a handoff, the request's bank is marked open on the request's row. A later request to that row is class 1, and a request to another row is class 2.
- R10: Banks are tracked independently. Opening a row in one bank does not change the class seen by requests to any other bank.
- R11: `iss_tid`, `iss_bank`, `iss_row` and `iss_col` carry exactly the fields of the request being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | A request is offered |
| enq_ready | output | 1 | The buffer has a free slot |
| enq_tid | input | 2 | Thread of the offered request |
| enq_bank | input | 2 | Target bank |
| enq_row | input | 14 | Target row |
| enq_col | input | 7 | Column (64-byte block within an 8 KB row) |
| iss_valid | output | 1 | A request is offered downstream |
| iss_ready | input | 1 | Downstream takes the offered request |
| iss_tid | output | 2 | Thread of the issued request |
| iss_bank | output | 2 | Bank of the issued request |
| iss_row | output | 14 | Row of the issued request |
| iss_col | output | 7 | Column of the issued request |
| iss_class | output | 2 | 0 no row open, 1 row hit, 2 row conflict |

## Verification
The case that is hardest to reach is a tie on both class and arrival stamp. Only one request is accepted per cycle, so two stamps can match only when the stamp counter has wrapped. The low-slot rule also shows only if the younger request sits in the lower slot.

The bench builds this case in steps. It fills slot 0 and slot 1, then lets only slot 0 drain. It then counts exactly 256 cycles from slot 1's acceptance and offers a new request, which lands in slot 0 with a matching stamp. Both requests target banks with other rows open, so they share the conflict class.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  parameter int unsigned TID_W  = 2;
  parameter int unsigned BANK_W = 2;
  parameter int unsigned ROW_W  = 14;
  parameter int unsigned COL_W  = 7;
  parameter int unsigned AGE_W  = 8;
  parameter int unsigned DEPTH  = 8;

  localparam int unsigned NUM_BANKS = 1 << BANK_W;
  localparam int unsigned IDX_W     = $clog2(DEPTH);

  typedef struct packed {
    logic [TID_W-1:0]  tid;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } req_t;

  typedef enum logic [1:0] {
    ROW_EMPTY    = 2'd0,
    ROW_HIT      = 2'd1,
    ROW_CONFLICT = 2'd2
  } row_class_e;
endpackage

// File: rtl/frfcfs_req_buf.sv
module frfcfs_req_buf
  import frfcfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_fire,
  input  req_t             enq_req,
  input  logic             deq_fire,
  input  logic [IDX_W-1:0] deq_idx,
  output logic [DEPTH-1:0] ent_valid,
  output req_t             ent_req   [DEPTH],
  output logic [AGE_W-1:0] ent_stamp [DEPTH],
  output logic [AGE_W-1:0] now,
  output logic [IDX_W-1:0] free_idx,
  output logic             full
);
  logic [DEPTH-1:0] valid_d;
  logic             free_found;

  // lowest free slot
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!ent_valid[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
    full = &ent_valid;
  end

  always_comb begin
    valid_d = ent_valid;
    if (deq_fire) valid_d[deq_idx] = 1'b0;
    if (enq_fire) valid_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      now       <= '0;
    end else begin
      ent_valid <= valid_d;
      now       <= now + AGE_W'(1);
    end
  end

  // payload: written only when a slot is claimed, no reset needed
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;
    assign wr_en = enq_fire && (free_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) begin
        ent_req[g]   <= enq_req;
        ent_stamp[g] <= now;
      end
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |-> !full);

  assert_no_silent_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_fire && !deq_fire) |=> $stable(ent_valid));
endmodule

// File: rtl/frfcfs_bank_state.sv
module frfcfs_bank_state
  import frfcfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic [NUM_BANKS-1:0] open_valid,
  output logic [ROW_W-1:0]     open_row [NUM_BANKS]
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    logic open_d;
    logic [ROW_W-1:0] row_d;
    assign sel = upd_en && (upd_bank == BANK_W'(b));

    always_comb begin
      open_d = open_valid[b];
      row_d  = open_row[b];
      if (sel) begin
        open_d = 1'b1;
        row_d  = upd_row;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_valid[b] <= 1'b0;
        open_row[b]   <= '0;
      end else begin
        open_valid[b] <= open_d;
        open_row[b]   <= row_d;
      end
    end
  end

  assert_row_opened_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (open_valid[$past(upd_bank)] && open_row[$past(upd_bank)] == $past(upd_row)));
endmodule

// File: rtl/frfcfs_pick.sv
module frfcfs_pick
  import frfcfs_pkg::*;
(
  input  logic [DEPTH-1:0]     ent_valid,
  input  req_t                 ent_req   [DEPTH],
  input  logic [AGE_W-1:0]     ent_stamp [DEPTH],
  input  logic [AGE_W-1:0]     now,
  input  logic [NUM_BANKS-1:0] open_valid,
  input  logic [ROW_W-1:0]     open_row [NUM_BANKS],
  output logic                 any_valid,
  output logic [IDX_W-1:0]     sel_idx,
  output row_class_e           sel_class,
  output logic [DEPTH-1:0]     hit_vec
);
  row_class_e       cls [DEPTH];
  logic [AGE_W-1:0] age [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cls
    always_comb begin
      if (!open_valid[ent_req[g].bank])
        cls[g] = ROW_EMPTY;
      else if (open_row[ent_req[g].bank] == ent_req[g].row)
        cls[g] = ROW_HIT;
      else
        cls[g] = ROW_CONFLICT;
    end
    assign hit_vec[g] = ent_valid[g] && (cls[g] == ROW_HIT);
    assign age[g]     = now - ent_stamp[g];  // wrap-safe distance
  end

  // scan: hit class first, then larger age; strict compare keeps lowest index
  always_comb begin
    logic             found;
    logic             best_hit;
    logic [AGE_W-1:0] best_age;
    found    = 1'b0;
    best_hit = 1'b0;
    best_age = '0;
    sel_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_valid[i]) begin
        if (!found || (hit_vec[i] && !best_hit) ||
            (hit_vec[i] == best_hit && age[i] > best_age)) begin
          found    = 1'b1;
          best_hit = hit_vec[i];
          best_age = age[i];
          sel_idx  = IDX_W'(i);
        end
      end
    end
    any_valid = found;
    sel_class = cls[sel_idx];
  end
endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
  import frfcfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  output logic              enq_ready,
  input  logic [TID_W-1:0]  enq_tid,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic [COL_W-1:0]  enq_col,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [TID_W-1:0]  iss_tid,
  output logic [BANK_W-1:0] iss_bank,
  output logic [ROW_W-1:0]  iss_row,
  output logic [COL_W-1:0]  iss_col,
  output logic [1:0]        iss_class
);
  logic [DEPTH-1:0]     ent_valid;
  req_t                 ent_req   [DEPTH];
  logic [AGE_W-1:0]     ent_stamp [DEPTH];
  logic [AGE_W-1:0]     now;
  logic [IDX_W-1:0]     free_idx;
  logic                 full;
  logic [NUM_BANKS-1:0] open_valid;
  logic [ROW_W-1:0]     open_row [NUM_BANKS];
  logic                 any_valid;
  logic [IDX_W-1:0]     sel_idx;
  row_class_e           sel_class;
  logic [DEPTH-1:0]     hit_vec;
  logic                 enq_fire;
  logic                 iss_fire;
  req_t                 enq_req;
  req_t                 sel_req;

  assign enq_ready = !full;
  assign enq_fire  = enq_valid && !full;
  assign enq_req   = '{tid: enq_tid, bank: enq_bank, row: enq_row, col: enq_col};
  assign iss_fire  = any_valid && iss_ready;

  frfcfs_req_buf i_buf (
    .clk, .rst_n,
    .enq_fire, .enq_req,
    .deq_fire (iss_fire),
    .deq_idx  (sel_idx),
    .ent_valid, .ent_req, .ent_stamp, .now, .free_idx, .full
  );

  frfcfs_bank_state i_banks (
    .clk, .rst_n,
    .upd_en   (iss_fire),
    .upd_bank (sel_req.bank),
    .upd_row  (sel_req.row),
    .open_valid, .open_row
  );

  frfcfs_pick i_pick (
    .ent_valid, .ent_req, .ent_stamp, .now,
    .open_valid, .open_row,
    .any_valid, .sel_idx, .sel_class, .hit_vec
  );

  assign sel_req   = ent_req[sel_idx];
  assign iss_valid = any_valid;
  assign iss_tid   = sel_req.tid;
  assign iss_bank  = sel_req.bank;
  assign iss_row   = sel_req.row;
  assign iss_col   = sel_req.col;
  assign iss_class = sel_class;

  assert_hit_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_class != ROW_HIT) |-> (hit_vec == '0));

  assert_fresh_not_offered_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |-> !(iss_valid && sel_idx == free_idx));

  assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> iss_valid);

  assert_class_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (iss_class != 2'd3));
endmodule

// File: tb/test_frfcfs_sched.sv
module test_frfcfs_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [1:0]  enq_tid = '0;
  logic [1:0]  enq_bank = '0;
  logic [13:0] enq_row = '0;
  logic [6:0]  enq_col = '0;
  logic        iss_valid;
  logic        iss_ready = 1'b0;
  logic [1:0]  iss_tid;
  logic [1:0]  iss_bank;
  logic [13:0] iss_row;
  logic [6:0]  iss_col;
  logic [1:0]  iss_class;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_drive = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frfcfs_sched i_frfcfs_sched (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enq(input logic [1:0] t, input logic [1:0] b,
                     input logic [13:0] r, input logic [6:0] c);
    @(negedge clk);
    enq_valid = 1'b1; enq_tid = t; enq_bank = b; enq_row = r; enq_col = c;
    last_drive = cyc;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic take(input string req, input logic [1:0] t, input logic [1:0] b,
                      input logic [13:0] r, input logic [6:0] c, input logic [1:0] k);
    @(negedge clk);
    chk({req, " valid"}, 32'(iss_valid), 1);
    chk({"R11 tid ", req}, 32'(iss_tid), 32'(t));
    chk({"R11 bank ", req}, 32'(iss_bank), 32'(b));
    chk({"R11 row ", req}, 32'(iss_row), 32'(r));
    chk({"R11 col ", req}, 32'(iss_col), 32'(c));
    chk({"R4 class ", req}, 32'(iss_class), 32'(k));
    iss_ready = 1'b1;
    @(negedge clk);
    iss_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 enq_ready", 32'(enq_ready), 1);
    chk("R1 iss_valid", 32'(iss_valid), 0);
  endtask

  task automatic t_first_access;
    @(negedge clk);
    enq_valid = 1'b1; enq_tid = 2'd1; enq_bank = 2'd0; enq_row = 14'd100; enq_col = 7'd5;
    #1 chk("R3 not offered before accept edge", 32'(iss_valid), 0);
    @(negedge clk);
    enq_valid = 1'b0;
    chk("R3 offered after accept", 32'(iss_valid), 1);
    take("R1 first bank0 empty", 2'd1, 2'd0, 14'd100, 7'd5, 2'd0);
  endtask

  task automatic t_hit_first;
    enq(2'd2, 2'd0, 14'd200, 7'd10);
    enq(2'd3, 2'd0, 14'd100, 7'd11);
    take("R5 younger hit first", 2'd3, 2'd0, 14'd100, 7'd11, 2'd1);
    take("R9 conflict reopens", 2'd2, 2'd0, 14'd200, 7'd10, 2'd2);
  endtask

  task automatic t_oldest_first;
    enq(2'd0, 2'd1, 14'd3, 7'd20);
    enq(2'd1, 2'd2, 14'd4, 7'd21);
    enq(2'd2, 2'd3, 14'd5, 7'd22);
    take("R6 oldest empty", 2'd0, 2'd1, 14'd3, 7'd20, 2'd0);
    take("R6 second empty", 2'd1, 2'd2, 14'd4, 7'd21, 2'd0);
    take("R6 third empty", 2'd2, 2'd3, 14'd5, 7'd22, 2'd0);
    enq(2'd1, 2'd0, 14'd200, 7'd23);
    take("R10 bank0 row unchanged by others", 2'd1, 2'd0, 14'd200, 7'd23, 2'd1);
  endtask

  task automatic t_full;
    for (int i = 0; i < 8; i++) enq(2'(i), 2'd0, 14'd200, 7'(i));
    @(negedge clk);
    chk("R2 not ready when full", 32'(enq_ready), 0);
    enq_valid = 1'b1; enq_bank = 2'd0; enq_row = 14'd200; enq_col = 7'd99;
    @(negedge clk);
    @(negedge clk);
    enq_valid = 1'b0;
    chk("R8 held while not ready", 32'(iss_valid), 1);
    chk("R8 same offer while not ready", 32'(iss_col), 0);
    for (int i = 0; i < 8; i++) take("R2 drain in order", 2'(i), 2'd0, 14'd200, 7'(i), 2'd1);
    @(negedge clk);
    chk("R2 dropped request never issued", 32'(iss_valid), 0);
    chk("R2 ready again", 32'(enq_ready), 1);
  endtask

  task automatic t_tie;
    int a_drive;
    enq(2'd0, 2'd0, 14'd200, 7'd1);   // slot 0, hit
    enq(2'd1, 2'd2, 14'd77, 7'd2);    // slot 1, conflict
    a_drive = last_drive;
    take("R5 hit before older-free", 2'd0, 2'd0, 14'd200, 7'd1, 2'd1);
    while (cyc != a_drive + 256) @(negedge clk);
    enq_valid = 1'b1; enq_tid = 2'd2; enq_bank = 2'd3; enq_row = 14'd77; enq_col = 7'd3;
    @(negedge clk);
    enq_valid = 1'b0;
    take("R7 equal stamp low slot wins", 2'd2, 2'd3, 14'd77, 7'd3, 2'd2);
    take("R7 other slot next", 2'd1, 2'd2, 14'd77, 7'd2, 2'd2);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_first_access;
    t_hit_first;
    t_oldest_first;
    t_full;
    t_tie;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule